// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages an on-chip Ethernet packet buffer. The buffer is split into fixed 256-byte pages. A host drives a small register port. It writes a command word to reserve some pages under a packet number, or to return pages. It can also place a packet number on the transmit queue, or take the head packet off the receive queue, either keeping its pages or returning them. The MAC side uses two single-cycle hooks: one adds a received packet number to the receive queue, and one removes the head of the transmit queue once that frame has gone out.

The block tracks three things: the number of free pages, which packet numbers are in use and how many pages each one holds, and the two queues of packet numbers. A programmable count of pages is kept back for transmit traffic, and host allocations may not use those pages. When a page return is started, the command register shows a busy bit for one cycle while the pages go back to the pool. A successful allocation raises a one-cycle pulse that an interrupt block can use.

Top module: `pba_alloc`

## Requirements
- R1: Register addresses are 0 = command, 1 = packet number (bits [6:0]), 2 = allocation result, 3 = queue heads, 4 = memory information, 5 = transmit reserve (bits [4:0]). The command code is bits [7:5] of a word written to address 0. Code 0 does nothing, whatever its low bits hold.
- R2: Code 1 asks for (bits [2:0] + 1) pages. It succeeds when a packet number is free and the free page count is at least the request plus the reserve. On success, after the write edge, the result register reads the lowest free packet number in bits [6:0] with bit 7 clear, the free count drops by the request, and `alloc_done` is high for exactly that one cycle.
- R3: A failed allocation sets the result register to 0x0080, leaves the free count unchanged and raises no `alloc_done`. This applies both to a page shortage and to having no free packet number.
- R4: The reserve written at address 5 takes part in every later allocation decision.
- R5: Codes 4 and 5 start a return. Bit 0 of the command register reads 1 for exactly the cycle after the write edge, and the pages are back in the pool one edge later. Command writes that arrive while busy is 1 are ignored.
- R6: Code 5 returns the pages of the packet named in the packet-number register. Naming a packet number that is not allocated changes no count.
- R7: Code 6 appends the packet-number register to the transmit queue. A `tx_pop` pulse removes the head, oldest first, and a pop on an empty queue does nothing.
- R8: A `rx_push` pulse appends `rx_pkt` to the receive queue. Code 3 removes the head without returning pages. Code 4 removes the head and returns its pages. With the receive queue empty, codes 3 and 4 do nothing and raise no busy.
- R9: Code 7 empties the transmit queue and leaves the page counts untouched.
- R10: Code 2 makes every page and packet number free, empties both queues and sets the result to 0x0080, all at one edge.
- R11: Address 3 reads {rx_empty, rx_head[6:0], tx_empty, tx_head[6:0]}, with a head reading 0 when its queue is empty. Address 4 reads free pages in bits [15:8] and total pages in bits [7:0].
- R12: After synchronous reset, free pages equal the total, both queues are empty, busy is 0, the reserve is 0 and the result reads 0x0080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational register read data |
| rx_push | input | 1 | MAC adds `rx_pkt` to the receive queue |
| rx_pkt | input | 7 | Packet number of a received frame |
| tx_pop | input | 1 | MAC removes the transmit queue head |
| tx_head | output | 7 | Current transmit queue head |
| tx_empty | output | 1 | Transmit queue is empty |
| alloc_done | output | 1 | One-cycle pulse on a granted allocation |

## Verification
If a page count is lost or added by mistake, the free-page byte at address 4 shows the wrong value at the next read after the return completes, which is two edges after the command. A wrong packet-use map shows up either as a repeated packet number in the result register or as a page return that changes nothing. The bench reads the free count right after each grant, each refusal and each return. A queue-pointer fault shows up at the heads register on the first read after a push or pop out of order, so the bench checks the heads after each push or pop, including on empty queues.

// File: rtl/pba_pkg.sv
package pba_pkg;
    localparam int PKT_W = 7;
    localparam int DW    = 16;
    localparam int REQ_W = 3;
    localparam int RSV_W = 5;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_ALLOC   = 3'd1,
        CMD_RESET   = 3'd2,
        CMD_RX_DROP = 3'd3,
        CMD_RX_FREE = 3'd4,
        CMD_FREE    = 3'd5,
        CMD_TX_PUSH = 3'd6,
        CMD_TX_CLR  = 3'd7
    } mmu_cmd_e;

    typedef enum logic [2:0] {
        RA_CMD     = 3'd0,
        RA_PNUM    = 3'd1,
        RA_RESULT  = 3'd2,
        RA_QHEAD   = 3'd3,
        RA_MEMINFO = 3'd4,
        RA_RSV     = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic             fail;
        logic [PKT_W-1:0] pkt;
    } alloc_res_t;

    typedef struct packed {
        logic             rx_empty;
        logic [PKT_W-1:0] rx_head;
        logic             tx_empty;
        logic [PKT_W-1:0] tx_head;
    } qhead_t;

    function automatic mmu_cmd_e cmd_of(input logic [DW-1:0] w);
        return mmu_cmd_e'(w[7:5]);
    endfunction
endpackage

// File: rtl/pba_pkt_fifo.sv
module pba_pkt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
    assign empty   = (cnt_q == '0);
    assign head    = empty ? '0 : mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R7 / R8: occupancy never exceeds the storage
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
    // R8: popping an empty queue leaves it empty
    a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !clear) |=> empty);
endmodule

// File: rtl/pba_page_pool.sv
module pba_page_pool
    import pba_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int NUM_PKTS  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             alloc_req,
    input  logic [REQ_W-1:0] alloc_m1,
    input  logic [RSV_W-1:0] reserve,
    input  logic             rel_req,
    input  logic [PKT_W-1:0] rel_pkt,
    output logic [7:0]       free_pages,
    output alloc_res_t       result,
    output logic             alloc_done,
    output logic             busy
);
    localparam int PG_W   = $clog2(NUM_PAGES + 1);
    localparam int SLOT_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
    localparam int CW     = PG_W + RSV_W + REQ_W + 1;

    logic [NUM_PKTS-1:0] used_q;
    logic [PG_W-1:0]     pages_q [NUM_PKTS];
    logic [PG_W-1:0]     free_q;
    logic                busy_q, done_q;
    logic [PKT_W-1:0]    rel_q;
    alloc_res_t          result_q;

    logic              found, grant, alloc_ok, rel_ok, ret, in_range;
    logic [SLOT_W-1:0] slot, rel_idx;
    logic [CW-1:0]     need;
    logic [PG_W-1:0]   take, give;

    // lowest unused packet number wins
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                found = 1'b1;
                slot  = SLOT_W'(i);
            end
        end
    end

    assign alloc_ok = alloc_req && !busy_q;
    assign rel_ok   = rel_req && !busy_q;
    assign need     = CW'(alloc_m1) + CW'(1);
    assign grant    = alloc_ok && found && (CW'(free_q) >= need + CW'(reserve));
    assign rel_idx  = rel_q[SLOT_W-1:0];
    assign in_range = rel_q < PKT_W'(NUM_PKTS);
    assign ret      = busy_q && in_range && used_q[rel_idx];
    assign take     = grant ? PG_W'(need) : '0;
    assign give     = ret ? pages_q[rel_idx] : '0;

    always_ff @(posedge clk) begin
        if (grant && !clear) pages_q[slot] <= PG_W'(need);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            used_q   <= '0;
            free_q   <= PG_W'(NUM_PAGES);
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            rel_q    <= '0;
            result_q <= '{fail: 1'b1, pkt: '0};
        end else begin
            done_q <= grant;
            if (grant) begin
                used_q[slot] <= 1'b1;
                result_q     <= '{fail: 1'b0, pkt: PKT_W'(slot)};
            end else if (alloc_ok) begin
                result_q <= '{fail: 1'b1, pkt: '0};
            end
            if (rel_ok) begin
                busy_q <= 1'b1;
                rel_q  <= rel_pkt;
            end else if (busy_q) begin
                busy_q <= 1'b0;
                if (ret) used_q[rel_idx] <= 1'b0;
            end
            free_q <= free_q - take + give;
        end
    end

    assign free_pages = 8'(free_q);
    assign result     = result_q;
    assign alloc_done = done_q;
    assign busy       = busy_q;

    // R2: free count is bounded by the pool size
    a_r2_free_bound: assert property (@(posedge clk) disable iff (rst)
        free_q <= PG_W'(NUM_PAGES));
    // R2: a completion pulse always comes with a granted result
    a_r2_done_granted: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> !result.fail);
    // R3: a refused request leaves the free count alone
    a_r3_fail_keeps_free: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && !clear) |=> (result.fail -> (free_q == $past(free_q))));
    // R5: busy lasts a single cycle
    a_r5_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    // R10: the reset command refills the pool
    a_r10_clear_full: assert property (@(posedge clk) disable iff (rst)
        clear |=> (free_q == PG_W'(NUM_PAGES)) && result.fail);
endmodule

// File: rtl/pba_alloc.sv
module pba_alloc
    import pba_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int NUM_PKTS  = 8,
    parameter int QDEPTH    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             rx_push,
    input  logic [PKT_W-1:0] rx_pkt,
    input  logic             tx_pop,
    output logic [PKT_W-1:0] tx_head,
    output logic             tx_empty,
    output logic             alloc_done
);
    logic [PKT_W-1:0] pnr_q;
    logic [RSV_W-1:0] rsv_q;

    logic             busy, cmd_wr, rx_empty;
    logic             alloc_req, rel_req, rx_pop, tx_push, clear_all, tx_clear;
    logic [PKT_W-1:0] rx_head, rel_pkt;
    logic [7:0]       free_pages;
    alloc_res_t       result;
    mmu_cmd_e         cmd;
    qhead_t           qh;
    logic             unused_hi;

    assign unused_hi = ^wr_data[15:8];

    assign cmd       = cmd_of(wr_data);
    assign cmd_wr    = wr_en && (wr_addr == RA_CMD) && !busy;
    assign alloc_req = cmd_wr && (cmd == CMD_ALLOC);
    assign rx_pop    = cmd_wr && ((cmd == CMD_RX_DROP) || (cmd == CMD_RX_FREE));
    assign rel_req   = cmd_wr && (((cmd == CMD_RX_FREE) && !rx_empty) || (cmd == CMD_FREE));
    assign rel_pkt   = (cmd == CMD_RX_FREE) ? rx_head : pnr_q;
    assign tx_push   = cmd_wr && (cmd == CMD_TX_PUSH);
    assign clear_all = cmd_wr && (cmd == CMD_RESET);
    assign tx_clear  = clear_all || (cmd_wr && (cmd == CMD_TX_CLR));

    always_ff @(posedge clk) begin
        if (rst) begin
            pnr_q <= '0;
            rsv_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_PNUM) pnr_q <= wr_data[PKT_W-1:0];
            if (wr_addr == RA_RSV)  rsv_q <= wr_data[RSV_W-1:0];
        end
    end

    pba_page_pool #(.NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS)) u_pool (
        .clk(clk), .rst(rst), .clear(clear_all),
        .alloc_req(alloc_req), .alloc_m1(wr_data[REQ_W-1:0]), .reserve(rsv_q),
        .rel_req(rel_req), .rel_pkt(rel_pkt),
        .free_pages(free_pages), .result(result),
        .alloc_done(alloc_done), .busy(busy)
    );

    pba_pkt_fifo #(.DEPTH(QDEPTH), .W(PKT_W)) u_txq (
        .clk(clk), .rst(rst), .clear(tx_clear),
        .push(tx_push), .din(pnr_q), .pop(tx_pop),
        .head(tx_head), .empty(tx_empty)
    );

    pba_pkt_fifo #(.DEPTH(QDEPTH), .W(PKT_W)) u_rxq (
        .clk(clk), .rst(rst), .clear(clear_all),
        .push(rx_push), .din(rx_pkt), .pop(rx_pop),
        .head(rx_head), .empty(rx_empty)
    );

    assign qh = '{rx_empty: rx_empty, rx_head: rx_head, tx_empty: tx_empty, tx_head: tx_head};

    always_comb begin
        case (rd_addr)
            RA_CMD:     rd_data = {15'd0, busy};
            RA_PNUM:    rd_data = DW'(pnr_q);
            RA_RESULT:  rd_data = DW'(result);
            RA_QHEAD:   rd_data = qh;
            RA_MEMINFO: rd_data = {free_pages, 8'(NUM_PAGES)};
            RA_RSV:     rd_data = DW'(rsv_q);
            default:    rd_data = '0;
        endcase
    end

    // R1: a no-op command moves no pages
    a_r1_nop_still: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd == CMD_NOP)) |=> (free_pages == $past(free_pages)));
    // R9: the transmit-queue reset leaves the queue empty and pages alone
    a_r9_txclr: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd == CMD_TX_CLR)) |=> tx_empty && (free_pages == $past(free_pages)));
    // R10: the full reset empties the receive queue as well
    a_r10_rx_cleared: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> rx_empty && tx_empty);
endmodule

// File: tb/pba_alloc_bench.sv
module pba_alloc_bench;
    typedef struct packed {
        logic        we;
        logic [2:0]  wa;
        logic [15:0] wd;
        logic [2:0]  ra;
        logic [15:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h1010, 4'd12}, // R12 mem info
        '{1'b0, 3'd0, 16'h0000, 3'd2, 16'h0080, 4'd12}, // R12 result
        '{1'b0, 3'd0, 16'h0000, 3'd3, 16'h8080, 4'd12}, // R12 queues empty
        '{1'b1, 3'd0, 16'h0022, 3'd2, 16'h0000, 4'd2},  // R2 3 pages -> pkt 0
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0D10, 4'd11}, // R11 free 13
        '{1'b1, 3'd0, 16'h0020, 3'd2, 16'h0001, 4'd2},  // R2 1 page -> pkt 1
        '{1'b1, 3'd5, 16'h0008, 3'd4, 16'h0C10, 4'd4},  // R4 reserve 8
        '{1'b1, 3'd0, 16'h0024, 3'd2, 16'h0080, 4'd3},  // R3 5+8 > 12
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0C10, 4'd3},  // R3 count kept
        '{1'b1, 3'd0, 16'h0023, 3'd2, 16'h0002, 4'd4},  // R4 4+8 == 12 granted
        '{1'b1, 3'd5, 16'h0000, 3'd4, 16'h0810, 4'd4},  // R4 reserve back to 0
        '{1'b1, 3'd1, 16'h0001, 3'd1, 16'h0001, 4'd6},  // R6 pnr = 1
        '{1'b1, 3'd0, 16'h00A0, 3'd0, 16'h0001, 4'd5},  // R5 busy after free
        '{1'b0, 3'd0, 16'h0000, 3'd0, 16'h0000, 4'd5},  // R5 busy gone
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0910, 4'd6},  // R6 one page back
        '{1'b1, 3'd0, 16'h00A0, 3'd4, 16'h0910, 4'd6},  // R6 free unallocated
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0910, 4'd6},  // R6 nothing changed
        '{1'b1, 3'd1, 16'h0002, 3'd1, 16'h0002, 4'd6},  // R6 pnr = 2
        '{1'b1, 3'd0, 16'h00A0, 3'd4, 16'h0910, 4'd5},  // R5 free pkt 2 started
        '{1'b1, 3'd0, 16'h0020, 3'd2, 16'h0002, 4'd5},  // R5 alloc while busy ignored
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0D10, 4'd5},  // R5 four pages back
        '{1'b1, 3'd1, 16'h0000, 3'd1, 16'h0000, 4'd7},  // R7 pnr = 0
        '{1'b1, 3'd0, 16'h00C0, 3'd3, 16'h8000, 4'd7},  // R7 enqueue pkt 0
        '{1'b1, 3'd1, 16'h0005, 3'd1, 16'h0005, 4'd7},  // R7 pnr = 5
        '{1'b1, 3'd0, 16'h00C0, 3'd3, 16'h8000, 4'd7},  // R7 head stays oldest
        '{1'b1, 3'd0, 16'h00E0, 3'd3, 16'h8080, 4'd9},  // R9 tx queue cleared
        '{1'b0, 3'd0, 16'h0000, 3'd4, 16'h0D10, 4'd9},  // R9 pages untouched
        '{1'b1, 3'd0, 16'h0040, 3'd4, 16'h1010, 4'd10}, // R10 reset command
        '{1'b0, 3'd0, 16'h0000, 3'd2, 16'h0080, 4'd10}, // R10 result cleared
        '{1'b1, 3'd0, 16'h0027, 3'd2, 16'h0000, 4'd10}, // R10 pkt 0 free again
        '{1'b1, 3'd0, 16'h0000, 3'd4, 16'h0810, 4'd1},  // R1 no-op
        '{1'b1, 3'd0, 16'h001F, 3'd4, 16'h0810, 4'd1}   // R1 no-op with low bits
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rx_push = 1'b0;
    logic [6:0]  rx_pkt = '0;
    logic        tx_pop = 1'b0;
    logic [6:0]  tx_head;
    logic        tx_empty;
    logic        alloc_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pba_alloc u_pba_alloc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_push(rx_push), .rx_pkt(rx_pkt),
        .tx_pop(tx_pop), .tx_head(tx_head), .tx_empty(tx_empty), .alloc_done(alloc_done)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input int rq, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [2:0] wa, input logic [15:0] wd);
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] ra, input logic [15:0] exp, input int rq, input string what);
        rd_addr = ra; #1;
        check(rd_data, exp, rq, what);
    endtask

    task automatic rxp(input logic [6:0] p);
        rx_push = 1'b1; rx_pkt = p;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic txp();
        tx_pop = 1'b1;
        @(posedge clk); #1;
        tx_pop = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].we, VECS[i].wa, VECS[i].wd);
            peek(VECS[i].ra, VECS[i].ex, int'(VECS[i].rq), $sformatf("vector %0d", i));
        end

        // R8 receive queue: push 0 then 3, drop keeps pages
        rxp(7'd0);
        rxp(7'd3);
        peek(3'd3, 16'h0080, 8, "rx head 0");
        cyc(1'b1, 3'd0, 16'h0060);
        peek(3'd3, 16'h0380, 8, "rx head 3 after drop");
        peek(3'd4, 16'h0810, 8, "drop returns nothing");
        cyc(1'b1, 3'd0, 16'h0060);
        peek(3'd3, 16'h8080, 8, "rx empty");
        cyc(1'b1, 3'd0, 16'h0060);
        peek(3'd3, 16'h8080, 8, "drop on empty");
        cyc(1'b1, 3'd0, 16'h0080);
        peek(3'd0, 16'h0000, 8, "free-head on empty no busy");
        rxp(7'd0);
        cyc(1'b1, 3'd0, 16'h0080);
        peek(3'd0, 16'h0001, 8, "free-head busy");
        peek(3'd3, 16'h8080, 8, "free-head popped");
        cyc(1'b0, 3'd0, 16'h0000);
        peek(3'd4, 16'h1010, 8, "free-head returned 8 pages");

        // R7 transmit queue with MAC pops
        cyc(1'b1, 3'd0, 16'h0020);
        check({15'd0, alloc_done}, 16'h0001, 2, "alloc_done pulse");
        peek(3'd2, 16'h0000, 2, "grant pkt 0");
        cyc(1'b0, 3'd0, 16'h0000);
        check({15'd0, alloc_done}, 16'h0000, 2, "alloc_done one cycle");
        cyc(1'b1, 3'd1, 16'h0000);
        cyc(1'b1, 3'd0, 16'h00C0);
        cyc(1'b1, 3'd0, 16'h0020);
        peek(3'd2, 16'h0001, 2, "grant pkt 1");
        cyc(1'b1, 3'd1, 16'h0001);
        cyc(1'b1, 3'd0, 16'h00C0);
        peek(3'd3, 16'h8000, 7, "tx head 0");
        check({8'd0, tx_empty, tx_head}, 16'h0000, 7, "tx port head 0");
        txp();
        peek(3'd3, 16'h8001, 7, "tx head 1 after pop");
        txp();
        peek(3'd3, 16'h8080, 7, "tx empty after pops");
        txp();
        peek(3'd3, 16'h8080, 7, "pop on empty tx");

        // R3 packet numbers exhausted
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 3'd0, 16'h0020);
            peek(3'd2, 16'(k + 2), 2, "grant sequential pkt");
        end
        cyc(1'b1, 3'd0, 16'h0020);
        peek(3'd2, 16'h0080, 3, "no packet number left");
        check({15'd0, alloc_done}, 16'h0000, 3, "no pulse on failure");
        peek(3'd4, 16'h0810, 3, "free count kept");

        // R12 synchronous reset mid-run
        cyc(1'b1, 3'd5, 16'h0003);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        peek(3'd4, 16'h1010, 12, "reset free pages");
        peek(3'd2, 16'h0080, 12, "reset result");
        peek(3'd3, 16'h8080, 12, "reset queues");
        peek(3'd0, 16'h0000, 12, "reset busy");
        peek(3'd5, 16'h0000, 12, "reset reserve");

        summary();
    end
endmodule